// File: doc/BRIEF.md
# XOR-Coded Contention Output Port

This block is one output port of an N-input switch (N from 2 to 4) that never makes a flit wait for arbitration before it is placed on the link. When only one input is requesting, its flit goes straight onto the link in the same cycle. When several inputs request together, the link carries the bitwise XOR of all of them, marked as coded. A round-robin arbiter then removes one contender per cycle from this collision group until a single flit remains, and that last flit is sent plain.

A receiving-side decoder is instantiated in the same top module, fed directly from the link outputs. It holds each link word for one cycle. It recovers a flit either by XORing the held coded word with the word that follows it, or by passing a held plain word through unchanged. The decoder therefore produces exactly one flit for every link word, one cycle later, in the order in which the arbiter removed the contenders.

An input must keep its valid and flit stable until it is granted. The link outputs are combinational from the inputs and the group state. The decoded outputs come from one register stage plus the current link word.

Top module: `xcs_output_port`

## Requirements
- R1: While reset is held and directly after it, `link_valid`, `dec_valid` and every `req_grant` bit are 0.
- R2: When the port is idle and exactly one input is requesting, in the same cycle `link_flit` equals that input's flit, `link_valid`=1, `link_coded`=0, and only that input's grant bit is 1.
- R3: When the port is idle and k≥2 inputs are requesting, in the same cycle `link_flit` is the XOR of those k flits and `link_coded`=1.
- R4: A collision group of k flits takes exactly k consecutive link cycles. In each of these cycles exactly one member of the group is granted. Each later word is the XOR of the members not yet granted. The last word carries the final member uncoded, with `link_coded`=0.
- R5: The arbiter searches in ascending input index, wrapping around, starting just after the most recently granted input; that input has the lowest priority. After reset, input 0 has the highest priority.
- R6: An input that raises valid while a group is being resolved is excluded from the link words and is not granted until that group's last word. It is admitted in the following cycle.
- R7: One cycle after each valid link word, `dec_valid`=1 and `dec_flit` equals the original flit that the arbiter granted in that earlier cycle. Decoded flits therefore come out in grant order.
- R8: One cycle after a cycle with `link_valid`=0, `dec_valid` is 0.
- R9: At most one `req_grant` bit is 1 in any cycle, and none is 1 when `link_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_IN | Per-input request, held until granted |
| req_flit | input | N_IN*FLIT_W | Per-input flits, input i in bits [i*FLIT_W +: FLIT_W] |
| req_grant | output | N_IN | Per-input grant, one-cycle pulse when the input leaves the XOR set |
| link_flit | output | FLIT_W | Link word: plain flit or XOR of the group's remaining members |
| link_valid | output | 1 | Link word is valid |
| link_coded | output | 1 | Link word still combines two or more flits |
| dec_flit | output | FLIT_W | Flit recovered by the receiving-side decoder |
| dec_valid | output | 1 | Recovered flit is valid |

## Verification
The link word, `link_coded` and the grant are combinational, so they are due in the same cycle as the input pattern and each later group step. The bench drives inputs on the falling edge and samples these outputs 5 ns later, before the next rising edge. The decoded flit for a link word is due one rising edge later. The bench checks it in the sample slot of the following cycle, against the flit it expects the arbiter to have granted one cycle before. Granted inputs are withdrawn on the falling edge after their grant, which matches the hold-until-granted contract.

// File: rtl/xcs_pkg.sv
package xcs_pkg;
    localparam int DEF_N_IN   = 3;
    localparam int DEF_FLIT_W = 16;
endpackage

// File: rtl/xcs_rr_pick.sv
// Round-robin picker: search starts one past the last granted index.
module xcs_rr_pick #(
    parameter int N_IN  = xcs_pkg::DEF_N_IN,
    parameter int IDX_W = 2
) (
    input  logic [N_IN-1:0]  active,
    input  logic [IDX_W-1:0] last_idx,
    output logic [N_IN-1:0]  win_oh,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_any
);
    always_comb begin
        int cand;
        win_oh  = '0;
        win_idx = '0;
        win_any = 1'b0;
        for (int off = 1; off <= N_IN; off++) begin
            cand = (int'(last_idx) + off) % N_IN;
            if (!win_any && active[cand]) begin
                win_any      = 1'b1;
                win_oh[cand] = 1'b1;
                win_idx      = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/xcs_xor_fold.sv
// XOR of all selected flits, built as a generated chain.
module xcs_xor_fold #(
    parameter int N_IN   = xcs_pkg::DEF_N_IN,
    parameter int FLIT_W = xcs_pkg::DEF_FLIT_W
) (
    input  logic [N_IN-1:0]        sel,
    input  logic [N_IN*FLIT_W-1:0] flits,
    output logic [FLIT_W-1:0]      folded
);
    logic [FLIT_W-1:0] part [N_IN+1];

    assign part[0] = '0;
    for (genvar g = 0; g < N_IN; g++) begin : g_fold
        assign part[g+1] = part[g] ^ (flits[g*FLIT_W +: FLIT_W] & {FLIT_W{sel[g]}});
    end
    assign folded = part[N_IN];
endmodule

// File: rtl/xcs_link_decoder.sv
// Receiving side: one-word hold register; a held coded word is undone with the next word.
module xcs_link_decoder #(
    parameter int FLIT_W = xcs_pkg::DEF_FLIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_valid,
    input  logic              link_coded,
    input  logic [FLIT_W-1:0] link_flit,
    output logic              dec_valid,
    output logic [FLIT_W-1:0] dec_flit
);
    typedef struct packed {
        logic              vld;
        logic              coded;
        logic [FLIT_W-1:0] word;
    } hold_t;

    hold_t hold_q, hold_d;

    always_comb begin
        hold_d.vld   = link_valid;
        hold_d.coded = link_valid & link_coded;
        hold_d.word  = link_valid ? link_flit : hold_q.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign dec_valid = hold_q.vld;
    assign dec_flit  = hold_q.coded ? (hold_q.word ^ link_flit) : hold_q.word;
endmodule

// File: rtl/xcs_output_port.sv
module xcs_output_port #(
    parameter int N_IN   = xcs_pkg::DEF_N_IN,
    parameter int FLIT_W = xcs_pkg::DEF_FLIT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        req_valid,
    input  logic [N_IN*FLIT_W-1:0] req_flit,
    output logic [N_IN-1:0]        req_grant,
    output logic [FLIT_W-1:0]      link_flit,
    output logic                   link_valid,
    output logic                   link_coded,
    output logic [FLIT_W-1:0]      dec_flit,
    output logic                   dec_valid
);
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

    typedef struct packed {
        logic             busy;
        logic [N_IN-1:0]  pending;
        logic [IDX_W-1:0] last;
    } grp_st_t;

    grp_st_t st_q, st_d;

    logic [N_IN-1:0]  active;
    logic [N_IN-1:0]  win_oh;
    logic [IDX_W-1:0] win_idx;
    logic             win_any;
    logic             multi;

    // A group in flight locks out late requesters.
    assign active = st_q.busy ? st_q.pending : req_valid;

    xcs_rr_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pick (
        .active   (active),
        .last_idx (st_q.last),
        .win_oh   (win_oh),
        .win_idx  (win_idx),
        .win_any  (win_any)
    );

    xcs_xor_fold #(.N_IN(N_IN), .FLIT_W(FLIT_W)) u_fold (
        .sel    (active),
        .flits  (req_flit),
        .folded (link_flit)
    );

    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < N_IN; i++) begin
            cnt += int'(active[i]);
        end
        multi = (cnt > 1);
    end

    assign link_valid = win_any;
    assign link_coded = multi;
    assign req_grant  = win_oh;

    always_comb begin
        st_d.busy    = multi;
        st_d.pending = active & ~win_oh;
        st_d.last    = win_any ? win_idx : st_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy    <= 1'b0;
            st_q.pending <= '0;
            st_q.last    <= IDX_W'(N_IN - 1);
        end else begin
            st_q <= st_d;
        end
    end

    xcs_link_decoder #(.FLIT_W(FLIT_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_valid (link_valid),
        .link_coded (link_coded),
        .link_flit  (link_flit),
        .dec_valid  (dec_valid),
        .dec_flit   (dec_flit)
    );
endmodule

// File: rtl/xcs_output_port_chk.sv
module xcs_output_port_chk #(
    parameter int N_IN = xcs_pkg::DEF_N_IN
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] req_grant,
    input logic            link_valid,
    input logic            link_coded,
    input logic            dec_valid
);
    // R9: never more than one grant
    assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant));

    // R9: no grant on an idle link
    assert_no_idle_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_valid |-> (req_grant == '0));

    // R4: a coded word is always followed by another word of its group
    assert_group_contiguous_R4: assert property (@(posedge clk) disable iff (!rst_n)
        link_coded |=> link_valid);

    // R2/R4: a plain word releases exactly one input
    assert_plain_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && !link_coded) |-> $countones(req_grant) == 1);

    // R7: every link word yields a decoded flit one cycle later
    assert_decode_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |=> dec_valid);

    // R8: an idle link cycle yields no decoded flit
    assert_idle_no_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !link_valid |=> !dec_valid);
endmodule

bind xcs_output_port xcs_output_port_chk #(.N_IN(N_IN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_grant  (req_grant),
    .link_valid (link_valid),
    .link_coded (link_coded),
    .dec_valid  (dec_valid)
);

// File: tb/tb_xcs_output_port.sv
`timescale 1ns/1ps
module tb_xcs_output_port;
    localparam int N  = 3;
    localparam int W  = 16;
    localparam int NV = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   vld = '0;
    logic [N*W-1:0] flt = '0;
    logic [N-1:0]   gnt;
    logic [W-1:0]   lflit, dflit;
    logic           lvld, lcod, dvld;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    xcs_output_port #(.N_IN(N), .FLIT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_flit(flt),
        .req_grant(gnt), .link_flit(lflit), .link_valid(lvld),
        .link_coded(lcod), .dec_flit(dflit), .dec_valid(dvld)
    );

    // {mask[10:8], count[7:6], order0[5:4], order1[3:2], order2[1:0]}
    // Orders follow R5 from the arbiter state left by the previous row.
    localparam logic [10:0] VEC [NV] = '{
        {3'b001, 2'd1, 2'd0, 2'd0, 2'd0},
        {3'b111, 2'd3, 2'd1, 2'd2, 2'd0},
        {3'b101, 2'd2, 2'd2, 2'd0, 2'd0},
        {3'b110, 2'd2, 2'd1, 2'd2, 2'd0},
        {3'b011, 2'd2, 2'd0, 2'd1, 2'd0},
        {3'b111, 2'd3, 2'd2, 2'd0, 2'd1},
        {3'b100, 2'd1, 2'd2, 2'd0, 2'd0}
    };

    function automatic logic [W-1:0] mk_flit(input int e, input int i);
        return W'(16'h3C5A ^ (e * 16'h1357) ^ ((i + 1) * 16'h0F21));
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_entry(input int e);
        logic [2:0]   mask;
        int           n;
        int           ord [3];
        logic [W-1:0] f [3];
        logic [W-1:0] expw;
        mask   = VEC[e][10:8];
        n      = int'(VEC[e][7:6]);
        ord[0] = int'(VEC[e][5:4]);
        ord[1] = int'(VEC[e][3:2]);
        ord[2] = int'(VEC[e][1:0]);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            f[i] = mk_flit(e, i);
            flt[i*W +: W] = f[i];
        end
        vld = mask;
        for (int s = 0; s < n; s++) begin
            #5;
            expw = '0;
            for (int r = s; r < n; r++) expw ^= f[ord[r]];
            chk(s == 0 ? (n == 1 ? "R2 link word" : "R3 xor word") : "R4 reduced word", lflit, expw);
            chk("R4 coded flag", W'(lcod), W'((n - s) > 1));
            chk("R5 grant", W'(gnt), W'(3'b001 << ord[s]));
            if (s > 0) chk("R7 decoded flit", dflit, f[ord[s-1]]);
            @(negedge clk);
            vld[ord[s]] = 1'b0;
        end
        #5;
        chk("R7 decoded last valid", W'(dvld), W'(1));
        chk("R7 decoded last flit", dflit, f[ord[n-1]]);
        chk("R9 idle link", W'({lvld, gnt}), W'(0));
        @(negedge clk);
        #5;
        chk("R8 no decode after idle", W'(dvld), W'(0));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (2) @(negedge clk);
        #5;
        chk("R1 link_valid in reset", W'(lvld), W'(0));
        chk("R1 dec_valid in reset", W'(dvld), W'(0));
        chk("R1 grant in reset", W'(gnt), W'(0));
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R1 after reset", W'({lvld, dvld, gnt}), W'(0));

        for (int e = 0; e < NV; e++) run_entry(e);

        // R6: input 2 raises valid while inputs 0,1 are being resolved (last grant was input 2)
        @(negedge clk);
        flt[0*W +: W] = 16'h1111;
        flt[1*W +: W] = 16'h2222;
        flt[2*W +: W] = 16'h4444;
        vld = 3'b011;
        #5;
        chk("R6 first word", lflit, 16'h3333);
        chk("R6 first grant", W'(gnt), W'(3'b001));
        @(negedge clk);
        vld = 3'b110;
        #5;
        chk("R6 late input excluded", lflit, 16'h2222);
        chk("R6 late input not granted", W'({lcod, gnt}), W'(4'b0010));
        chk("R7 decoded first", dflit, 16'h1111);
        @(negedge clk);
        vld = 3'b100;
        #5;
        chk("R6 late input admitted", lflit, 16'h4444);
        chk("R6 late grant", W'({lcod, gnt}), W'(4'b0100));
        chk("R7 decoded second", dflit, 16'h2222);
        @(negedge clk);
        vld = 3'b000;
        #5;
        chk("R7 decoded late", dflit, 16'h4444);
        chk("R9 idle after late", W'({lvld, gnt}), W'(0));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule